// File: doc/BRIEF.md
# Mailbox Command Handshake Engine

This block is a byte-wide register mailbox. A host uses it to hand indirect commands to an engine inside the chip. The host follows a fixed sequence:

1. Write four payload bytes.
2. Set a self-clearing go bit.
3. Poll a busy bit until it falls.
4. Write one to a sticky completion flag to acknowledge it.

Toward the engine, the block raises a one-cycle command strobe. A 32-bit payload travels with the strobe and comes from a shadow copy of the payload bytes. The block then waits for the engine's done pulse. The block does not interpret the commands it carries.

The host bus is a plain single-cycle byte bus. A write happens on any clock edge where the write enable is high. Read data depends only on the address, with no added register. The engine side has no back-pressure. The strobe is never repeated, and the engine must capture the payload during the strobe cycle or while busy stays high. The engine ends a command by pulsing done once.

Top module: `mbx_cmd_engine`

## Requirements
- R1: After reset, the four payload bytes, the flag and busy all read as zero, and the command strobe is low.
- R2: Payload bytes are read/write registers at 0x84, 0x85, 0x86 and 0x87. They map in that order to payload bits [7:0], [15:8], [23:16] and [31:24].
- R3: A write to 0x90 with data bit 0 set, while busy is low, produces the following on the next cycle:
  - the command strobe is high for exactly one cycle;
  - the payload equals the four bytes as they stood at the go write.
  A write to 0x90 with bit 0 clear starts nothing.
- R4: Address 0x90 always reads back 0x00.
- R5: Acceptance of a command sets the flag, seen as bit 7 of 0x8A. All other bits of 0x8A read 0.
- R6: Writing 0x8A with bit 7 set clears the flag. Writing 0x8A with bit 7 clear leaves the flag unchanged.
- R7: Busy, read as bit 0 of 0x8B, rises together with the strobe. It stays high until a clock edge that samples done high, and it lasts at least one cycle.
- R8: A go written while busy is high is ignored: no strobe occurs and busy is unchanged.
- R9: Payload byte writes during busy change the readable bytes but not the engine payload.
- R10: Reads of unmapped addresses return 0x00. Writes to unmapped addresses change no register.
- R11: A done pulse while busy is low has no effect on busy, the flag or the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr_en | input | 1 | Host write enable, one write per cycle |
| host_addr | input | 8 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for host_addr, combinational |
| eng_cmd_stb | output | 1 | One-cycle command start toward the engine |
| eng_cmd_payload | output | 32 | Shadowed command payload |
| eng_done | input | 1 | Engine completion pulse |

## Verification
Two situations are hard to reach from the ports:
- **Shortest busy window.** Done arrives on the very first edge after the strobe. To reach it, the bench raises done immediately after the go write returns, before any poll.
- **Payload isolation.** Fresh payload bytes and a second go must land while a command is still running. The bench holds done low for several cycles to reach this.

A scoreboard queue holds one expected payload per accepted go. Any strobe that arrives with the queue empty is reported, so an ignored go that still fires is caught.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned MBX_ADDR_W    = 8;
  localparam int unsigned MBX_BYTE_W    = 8;
  localparam int unsigned MBX_NUM_BYTES = 4;
  localparam logic [7:0]  MBX_PLD_BASE  = 8'h84;
  localparam logic [7:0]  MBX_FLAG_ADDR = 8'h8A;
  localparam logic [7:0]  MBX_BUSY_ADDR = 8'h8B;
  localparam logic [7:0]  MBX_GO_ADDR   = 8'h90;
  localparam int unsigned MBX_FLAG_BIT  = 7;
  localparam int unsigned MBX_BUSY_BIT  = 0;
  localparam int unsigned MBX_GO_BIT    = 0;
endpackage

// File: rtl/mbx_payload_regs.sv
module mbx_payload_regs #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned NUM_BYTES = 4,
  parameter logic [ADDR_W-1:0] PLD_BASE = 8'h84,
  localparam int unsigned PW = BYTE_W * NUM_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              capture,
  output logic [PW-1:0]     live_o,
  output logic [PW-1:0]     shadow_o
);
  logic [NUM_BYTES-1:0] hit;
  logic [PW-1:0]        live_q;
  logic [PW-1:0]        shadow_q;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_hit
    assign hit[g] = wr_en && (addr == ADDR_W'(int'(PLD_BASE) + g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
    end else begin
      for (int i = 0; i < NUM_BYTES; i++) begin
        if (hit[i]) live_q[i*BYTE_W +: BYTE_W] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       shadow_q <= '0;
    else if (capture) shadow_q <= live_q;
  end

  assign live_o   = live_q;
  assign shadow_o = shadow_q;

  // R10
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (hit == '0)) |=> $stable(live_q));
endmodule

// File: rtl/mbx_handshake.sv
module mbx_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic go_req,
  input  logic flag_clr,
  input  logic done,
  output logic capture,
  output logic busy,
  output logic flag,
  output logic cmd_stb
);
  logic busy_q, flag_q, stb_q;
  logic accept;

  assign accept  = go_req && !busy_q;
  assign capture = accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      flag_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= accept;
      if (accept)              busy_q <= 1'b1;
      else if (busy_q && done) busy_q <= 1'b0;
      if (accept)              flag_q <= 1'b1;
      else if (flag_clr)       flag_q <= 1'b0;
    end
  end

  assign busy    = busy_q;
  assign flag    = flag_q;
  assign cmd_stb = stb_q;

  // R3
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb);
  // R7
  stb_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> busy);
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  // R8
  go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go_req) |=> !cmd_stb);
  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> flag);
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go_req) |=> (!busy && !cmd_stb));
endmodule

// File: rtl/mbx_decode.sv
module mbx_decode #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned NUM_BYTES = 4,
  parameter logic [ADDR_W-1:0] PLD_BASE  = 8'h84,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h8A,
  parameter logic [ADDR_W-1:0] BUSY_ADDR = 8'h8B,
  parameter logic [ADDR_W-1:0] GO_ADDR   = 8'h90,
  parameter int unsigned FLAG_BIT = 7,
  parameter int unsigned BUSY_BIT = 0,
  localparam int unsigned PW = BYTE_W * NUM_BYTES
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              go_bit,
  input  logic              flag_bit,
  input  logic [PW-1:0]     live,
  input  logic              flag,
  input  logic              busy,
  output logic              go_req,
  output logic              flag_clr,
  output logic [BYTE_W-1:0] rdata
);
  assign go_req   = wr_en && (addr == GO_ADDR) && go_bit;
  assign flag_clr = wr_en && (addr == FLAG_ADDR) && flag_bit;

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (addr == ADDR_W'(int'(PLD_BASE) + i)) rdata = live[i*BYTE_W +: BYTE_W];
    end
    if (addr == FLAG_ADDR) rdata[FLAG_BIT] = flag;
    if (addr == BUSY_ADDR) rdata[BUSY_BIT] = busy;
  end
endmodule

// File: rtl/mbx_cmd_engine.sv
module mbx_cmd_engine
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W    = MBX_ADDR_W,
  parameter int unsigned BYTE_W    = MBX_BYTE_W,
  parameter int unsigned NUM_BYTES = MBX_NUM_BYTES,
  parameter logic [ADDR_W-1:0] PLD_BASE  = MBX_PLD_BASE,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = MBX_FLAG_ADDR,
  parameter logic [ADDR_W-1:0] BUSY_ADDR = MBX_BUSY_ADDR,
  parameter logic [ADDR_W-1:0] GO_ADDR   = MBX_GO_ADDR,
  parameter int unsigned FLAG_BIT = MBX_FLAG_BIT,
  parameter int unsigned BUSY_BIT = MBX_BUSY_BIT,
  parameter int unsigned GO_BIT   = MBX_GO_BIT,
  localparam int unsigned PW = BYTE_W * NUM_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  output logic              eng_cmd_stb,
  output logic [PW-1:0]     eng_cmd_payload,
  input  logic              eng_done
);
  logic [PW-1:0] live;
  logic go_req, flag_clr, capture, busy, flag;

  mbx_decode #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES),
    .PLD_BASE(PLD_BASE), .FLAG_ADDR(FLAG_ADDR), .BUSY_ADDR(BUSY_ADDR),
    .GO_ADDR(GO_ADDR), .FLAG_BIT(FLAG_BIT), .BUSY_BIT(BUSY_BIT)
  ) u_decode (
    .wr_en(host_wr_en), .addr(host_addr),
    .go_bit(host_wdata[GO_BIT]), .flag_bit(host_wdata[FLAG_BIT]),
    .live(live), .flag(flag), .busy(busy),
    .go_req(go_req), .flag_clr(flag_clr), .rdata(host_rdata)
  );

  mbx_payload_regs #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .PLD_BASE(PLD_BASE)
  ) u_payload (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr_en), .addr(host_addr),
    .wdata(host_wdata), .capture(capture),
    .live_o(live), .shadow_o(eng_cmd_payload)
  );

  mbx_handshake u_hs (
    .clk(clk), .rst_n(rst_n), .go_req(go_req), .flag_clr(flag_clr),
    .done(eng_done), .capture(capture), .busy(busy), .flag(flag),
    .cmd_stb(eng_cmd_stb)
  );

  // R3
  stb_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmd_stb |-> (eng_cmd_payload == $past(live)));
  // R9
  payload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !eng_cmd_stb) |-> $stable(eng_cmd_payload));
  // R4
  go_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == GO_ADDR) |-> (host_rdata == '0));
endmodule

// File: tb/test_mbx_cmd_engine.sv
module test_mbx_cmd_engine;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic cmd_stb;
  logic [31:0] cmd_payload;
  logic done = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_cmd_engine i_mbx_cmd_engine (
    .clk(clk), .rst_n(rst_n), .host_wr_en(wr_en), .host_addr(addr),
    .host_wdata(wdata), .host_rdata(rdata), .eng_cmd_stb(cmd_stb),
    .eng_cmd_payload(cmd_payload), .eng_done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #1 check(req, {24'h0, rdata}, {24'h0, exp});
  endtask

  task automatic load(input logic [31:0] p);
    wr(8'h84, p[7:0]);  wr(8'h85, p[15:8]);
    wr(8'h86, p[23:16]); wr(8'h87, p[31:24]);
  endtask

  // scoreboard monitor: every strobe must match a queued expectation
  always @(negedge clk) begin
    if (rst_n && cmd_stb) begin
      if (exp_q.size() == 0) check("R8 unexpected strobe", 32'h1, 32'h0);
      else check("R3 payload", cmd_payload, exp_q.pop_front());
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 strobe", {31'h0, cmd_stb}, 32'h0);
    for (int i = 0; i < 4; i++) rd_chk("R1 payload byte", 8'h84 + 8'(i), 8'h00);
    rd_chk("R1 flag", 8'h8A, 8'h00);
    rd_chk("R1 busy", 8'h8B, 8'h00);

    // R2 readback
    load(32'hA1B2C3D4);
    rd_chk("R2 byte0", 8'h84, 8'hD4);
    rd_chk("R2 byte3", 8'h87, 8'hA1);

    // R3 go with bit0 clear starts nothing (monitor flags a strobe)
    wr(8'h90, 8'hFE);
    rd_chk("R3 no start busy", 8'h8B, 8'h00);

    // command A
    exp_q.push_back(32'hA1B2C3D4);
    wr(8'h90, 8'hFF);
    check("R7 busy with strobe", {31'h0, cmd_stb}, 32'h1);
    rd_chk("R3 strobe one cycle", 8'h8B, 8'h01);
    check("R3 strobe low", {31'h0, cmd_stb}, 32'h0);
    rd_chk("R4 go reads zero", 8'h90, 8'h00);
    rd_chk("R5 flag set", 8'h8A, 8'h80);

    // R9 payload writes during busy
    load(32'h11223344);
    check("R9 engine payload held", cmd_payload, 32'hA1B2C3D4);
    rd_chk("R9 live byte", 8'h86, 8'h22);
    // R8 go while busy
    wr(8'h90, 8'h01);
    rd_chk("R8 busy kept", 8'h8B, 8'h01);
    repeat (4) @(negedge clk);
    rd_chk("R7 busy held without done", 8'h8B, 8'h01);
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
    rd_chk("R7 busy cleared by done", 8'h8B, 8'h00);

    // R6 flag clear
    wr(8'h8A, 8'h7F);
    rd_chk("R6 flag kept", 8'h8A, 8'h80);
    wr(8'h8A, 8'h80);
    rd_chk("R6 flag cleared", 8'h8A, 8'h00);

    // R11 done while idle
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
    rd_chk("R11 busy idle", 8'h8B, 8'h00);
    rd_chk("R11 flag idle", 8'h8A, 8'h00);

    // R10 unmapped
    wr(8'h83, 8'hFF); wr(8'h88, 8'hFF); wr(8'h8C, 8'hFF);
    rd_chk("R10 read 0x83", 8'h83, 8'h00);
    rd_chk("R10 read 0x88", 8'h88, 8'h00);
    rd_chk("R10 read 0x8C", 8'h8C, 8'h00);
    rd_chk("R10 payload intact", 8'h84, 8'h44);
    rd_chk("R10 payload intact", 8'h87, 8'h11);

    // R7 minimum busy: done on first edge after strobe
    exp_q.push_back(32'h11223344);
    wr(8'h90, 8'h01);
    done = 1'b1;
    @(negedge clk); done = 1'b0;
    rd_chk("R7 min busy one cycle", 8'h8B, 8'h00);
    rd_chk("R5 flag on second command", 8'h8A, 8'h80);

    repeat (2) @(negedge clk);
    check("R3 all strobes seen", exp_q.size(), 32'h0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule